// File: doc/BRIEF.md
# Bit-Serial Memory Write Sequencer

This block sits behind a byte-wide serial control bus and turns write traffic into single-bit writes to speech storage. Each byte arrives with a flag marking it as a command or as data. A start-page command is followed by a two-byte page number. The block turns that page number into a bit address, then writes the bits of the data bytes that follow, one bit per cycle. It steps the address after every bit. A resume command goes on writing from wherever the address counter stopped. Any other command closes the write sequence.

Memory size is set in pages of `2**PAGE_BITS` bits. When the counter passes the last bit of the memory, it returns to zero and reports that with a one-cycle pulse. Serialising a byte takes eight cycles. The block therefore holds `in_ready` low while it still has more than one bit of the current byte to write.

Top module: `bitwr_sequencer`

## Requirements
- R1: After reset `mem_addr` is 0, `mem_we` and `wrap_pulse` are 0, and `in_ready` is 1.
- R2: A command byte 0x66 followed by two data bytes, high byte first, loads `mem_addr` with page × 1024, and the operand bytes cause no writes. The new address is visible the cycle after the second operand byte is taken.
- R3: In a write sequence, each data byte taken produces eight `mem_we` pulses on consecutive cycles, starting the cycle after it is taken. `mem_addr` rises by one after each pulse.
- R4: The bits of each data byte appear on `mem_wdata` most significant bit first.
- R5: A command byte 0x68 opens a write sequence at the current `mem_addr` and does not reload it.
- R6: The counter is loaded only once both operand bytes have arrived. A command byte taken between them abandons the load and leaves `mem_addr` unchanged.
- R7: A page number at or above `NUM_PAGES` (default 4096) is taken modulo `NUM_PAGES`, so page 0x1005 loads address 5 × 1024.
- R8: After the write to the last address (`NUM_PAGES`×1024−1), `mem_addr` returns to 0 and `wrap_pulse` is high for exactly that one following cycle.
- R9: Any command byte other than 0x66 or 0x68 ends the write sequence. Data bytes after it cause no writes and leave `mem_addr` unchanged.
- R10: `in_ready` is low while more than one bit of the current byte remains to be written. A byte offered while `in_ready` is low is not taken.
- R11: Data bytes offered after reset, before any write command, are taken but cause no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered |
| in_is_cmd | input | 1 | Offered byte is a command (1) or data/operand (0) |
| in_byte | input | 8 | Offered byte |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| mem_addr | output | 22 | Current bit address |
| mem_we | output | 1 | Bit write strobe |
| mem_wdata | output | 1 | Bit to write |
| wrap_pulse | output | 1 | Counter wrapped to zero after the last address |

## Verification
A loaded address becomes visible one cycle after the second operand byte is taken. The first write strobe of a data byte comes one cycle after that byte is taken, and its eight strobes then run on consecutive cycles. `wrap_pulse` follows the write to the last address by one cycle. The bench drives inputs and samples outputs on falling edges. Each accepted data byte pushes eight address/bit pairs onto a queue, and a monitor pops one pair every cycle that shows a strobe. An empty queue at a strobe, a missing strobe at the end of the run, or a wrap pulse in any cycle other than the one after the last address each count as failures.

// File: rtl/bitwr_pkg.sv
package bitwr_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned PAGE_NUM_W = 16;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_OP_HI  = 2'd1,
      SQ_OP_LO  = 2'd2,
      SQ_STREAM = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic                  load;
      logic [PAGE_NUM_W-1:0] page;
   } page_load_t;

endpackage

// File: rtl/bitwr_cmd_fsm.sv
module bitwr_cmd_fsm
   import bitwr_pkg::*;
#(
   parameter logic [7:0] CMD_START  = 8'h66,
   parameter logic [7:0] CMD_RESUME = 8'h68
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic                  take_is_cmd,
   input  logic [BYTE_W-1:0]     take_byte,
   output logic                  push,
   output logic [BYTE_W-1:0]     push_byte,
   output page_load_t            page_ld
);

   seq_state_e           state_q, state_d;
   logic [BYTE_W-1:0]    hi_q;
   logic                 take_data;

   assign take_data = take && !take_is_cmd;

   always_comb begin
      state_d = state_q;
      if (take && take_is_cmd) begin
         if (take_byte == CMD_START)       state_d = SQ_OP_HI;
         else if (take_byte == CMD_RESUME) state_d = SQ_STREAM;
         else                              state_d = SQ_IDLE;
      end else if (take_data) begin
         case (state_q)
            SQ_OP_HI: state_d = SQ_OP_LO;
            SQ_OP_LO: state_d = SQ_STREAM;
            default:  state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         hi_q    <= '0;
      end else begin
         state_q <= state_d;
         if (take_data && state_q == SQ_OP_HI) hi_q <= take_byte;
      end
   end

   assign push         = take_data && (state_q == SQ_STREAM);
   assign push_byte    = take_byte;
   assign page_ld.load = take_data && (state_q == SQ_OP_LO);
   assign page_ld.page = {hi_q, take_byte};

   AST_LOAD_OPENS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      page_ld.load |=> state_q == SQ_STREAM);                        // R2
   AST_CMD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_is_cmd && take_byte != CMD_START && take_byte != CMD_RESUME)
      |=> !push);                                                    // R9

endmodule

// File: rtl/bitwr_shifter.sv
module bitwr_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_byte,
   output logic              ready,
   output logic              bit_we,
   output logic              bit_val
);

   localparam int unsigned CNT_W = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  left_q;
   logic [DATA_W-1:0] shifted;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shifted = {shreg_q[DATA_W-2:0], 1'b0};
         assign bit_val = shreg_q[DATA_W-1];
      end else begin : g_lsb
         assign shifted = {1'b0, shreg_q[DATA_W-1:1]};
         assign bit_val = shreg_q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
      end else if (push) begin
         shreg_q <= push_byte;
         left_q  <= CNT_W'(DATA_W);
      end else if (left_q != '0) begin
         shreg_q <= shifted;
         left_q  <= left_q - 1'b1;
      end
   end

   assign ready  = (left_q <= CNT_W'(1));
   assign bit_we = (left_q != '0);

   AST_PUSH_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> ready);                                               // R10
   AST_STROBE_FOLLOWS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> bit_we);                                              // R3
   AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bit_we) |-> $past(push));                                // R9

endmodule

// File: rtl/bitwr_addr_ctr.sv
module bitwr_addr_ctr
   import bitwr_pkg::*;
#(
   parameter int unsigned PAGE_BITS = 10,
   parameter int unsigned NUM_PAGES = 4096
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  page_load_t                           page_ld,
   input  logic                                 step,
   output logic [$clog2(NUM_PAGES)+PAGE_BITS-1:0] addr,
   output logic                                 wrap
);

   localparam int unsigned PG_W    = $clog2(NUM_PAGES);
   localparam int unsigned ADDR_W  = PG_W + PAGE_BITS;
   localparam bit          IS_POW2 = (NUM_PAGES & (NUM_PAGES - 1)) == 0;
   localparam logic [ADDR_W-1:0] LAST_ADDR =
      ADDR_W'((longint'(NUM_PAGES) << PAGE_BITS) - 1);

   logic [PG_W-1:0]   page_eff;
   logic [ADDR_W-1:0] addr_q;
   logic              wrap_q;
   logic              at_last;

   generate
      if (IS_POW2) begin : g_trunc
         assign page_eff = page_ld.page[PG_W-1:0];
      end else begin : g_modulo
         logic [PAGE_NUM_W-1:0] page_mod;
         assign page_mod = page_ld.page % PAGE_NUM_W'(NUM_PAGES);
         assign page_eff = page_mod[PG_W-1:0];
      end
   endgenerate

   assign at_last = (addr_q == LAST_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         wrap_q <= 1'b0;
      end else if (page_ld.load) begin
         addr_q <= {page_eff, {PAGE_BITS{1'b0}}};
         wrap_q <= 1'b0;
      end else if (step) begin
         addr_q <= at_last ? '0 : addr_q + 1'b1;
         wrap_q <= at_last;
      end else begin
         wrap_q <= 1'b0;
      end
   end

   assign addr = addr_q;
   assign wrap = wrap_q;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !page_ld.load && !at_last) |=> addr_q == $past(addr_q) + 1'b1); // R3
   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !page_ld.load) |=> $stable(addr_q));                 // R5
   AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |-> addr_q == '0);                                      // R8
   AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |=> !wrap_q);                                           // R8
   AST_LOAD_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      page_ld.load |=> addr_q[PAGE_BITS-1:0] == '0);                 // R2

endmodule

// File: rtl/bitwr_sequencer.sv
module bitwr_sequencer
   import bitwr_pkg::*;
#(
   parameter int unsigned PAGE_BITS  = 10,
   parameter int unsigned NUM_PAGES  = 4096,
   parameter bit          MSB_FIRST  = 1'b1,
   parameter logic [7:0]  CMD_START  = 8'h66,
   parameter logic [7:0]  CMD_RESUME = 8'h68,
   localparam int unsigned ADDR_W    = $clog2(NUM_PAGES) + PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_is_cmd,
   input  logic [7:0]        in_byte,
   output logic              in_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_wdata,
   output logic              wrap_pulse
);

   initial begin
      assert (PAGE_BITS >= 1 && PAGE_BITS <= 20)
         else $error("PAGE_BITS out of range");
      assert (NUM_PAGES >= 2 && $clog2(NUM_PAGES) <= PAGE_NUM_W)
         else $error("NUM_PAGES out of range");
      assert (CMD_START != CMD_RESUME)
         else $error("command codes must differ");
   end

   logic              take;
   logic              push;
   logic [BYTE_W-1:0] push_byte;
   page_load_t        page_ld;
   logic              ser_ready;
   logic              bit_we;
   logic              bit_val;

   assign take     = in_valid && ser_ready;
   assign in_ready = ser_ready;

   bitwr_cmd_fsm #(
      .CMD_START  (CMD_START),
      .CMD_RESUME (CMD_RESUME)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (take),
      .take_is_cmd (in_is_cmd),
      .take_byte   (in_byte),
      .push        (push),
      .push_byte   (push_byte),
      .page_ld     (page_ld)
   );

   bitwr_shifter #(
      .DATA_W    (BYTE_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_byte (push_byte),
      .ready     (ser_ready),
      .bit_we    (bit_we),
      .bit_val   (bit_val)
   );

   bitwr_addr_ctr #(
      .PAGE_BITS (PAGE_BITS),
      .NUM_PAGES (NUM_PAGES)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .page_ld (page_ld),
      .step    (bit_we),
      .addr    (mem_addr),
      .wrap    (wrap_pulse)
   );

   assign mem_we    = bit_we;
   assign mem_wdata = bit_val;

   AST_NO_LOAD_MID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      page_ld.load |-> !mem_we);                                     // R6
   AST_WRAP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_pulse |-> $past(mem_we));                                 // R8

endmodule

// File: tb/bitwr_sequencer_bench.sv
module bitwr_sequencer_bench;

   localparam int PAGE_BITS = 10;
   localparam int NUM_PAGES = 4096;
   localparam int ADDR_W    = 22;
   localparam int SIZE      = NUM_PAGES * 1024;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_is_cmd = 1'b0;
   logic [7:0]        in_byte = '0;
   logic              in_ready;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_we;
   logic              mem_wdata;
   logic              wrap_pulse;

   always #2.5 clk = ~clk;

   bitwr_sequencer u_bitwr_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_is_cmd  (in_is_cmd),
      .in_byte    (in_byte),
      .in_ready   (in_ready),
      .mem_addr   (mem_addr),
      .mem_we     (mem_we),
      .mem_wdata  (mem_wdata),
      .wrap_pulse (wrap_pulse)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   logic [ADDR_W:0] exp_q[$];   // {bit, addr}
   int  m_state = 0;            // 0 idle, 1 hi, 2 lo, 3 stream
   logic [7:0] m_hi = '0;
   int  m_addr = 0;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: updates the model, queues expected bits, offers the byte.
   task automatic send(input bit c, input logic [7:0] b);
      while (!in_ready) @(negedge clk);
      if (c) begin
         if (b == 8'h66) m_state = 1;
         else if (b == 8'h68) m_state = 3;
         else m_state = 0;
      end else begin
         case (m_state)
            1: begin m_hi = b; m_state = 2; end
            2: begin m_addr = ({m_hi, b} % NUM_PAGES) * 1024; m_state = 3; end
            3: for (int i = 7; i >= 0; i--) begin
                  exp_q.push_back({b[i], ADDR_W'(m_addr)});
                  m_addr = (m_addr + 1) % SIZE;
               end
            default: ;
         endcase
      end
      in_valid = 1'b1; in_is_cmd = c; in_byte = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || mem_we) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: pops one expected bit per observed strobe.
   bit wrap_due = 1'b0;
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (wrap_due) check("R8 wrap pulse", int'(wrap_pulse), 1);
            else if (wrap_pulse) check("R8 unexpected wrap", 1, 0);
            wrap_due = 1'b0;
            if (mem_we) begin
               if (exp_q.size() == 0) begin
                  check("R9 R11 unexpected write", 1, 0);
               end else begin
                  logic [ADDR_W:0] e;
                  e = exp_q.pop_front();
                  check("R3 address", int'(mem_addr), int'(e[ADDR_W-1:0]));
                  check("R4 bit order", int'(mem_wdata), int'(e[ADDR_W]));
                  if (int'(e[ADDR_W-1:0]) == SIZE - 1) wrap_due = 1'b1;
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 addr", int'(mem_addr), 0);
      check("R1 we", int'(mem_we), 0);
      check("R1 wrap", int'(wrap_pulse), 0);
      check("R1 ready", int'(in_ready), 1);
      mon_on = 1'b1;

      // R11 data before any command
      send(0, 8'hAA); send(0, 8'h55);
      drain();
      check("R11 addr untouched", int'(mem_addr), 0);

      // R2 start page 3
      send(1, 8'h66); send(0, 8'h00);
      check("R6 no load after high byte", int'(mem_addr), 0);
      send(0, 8'h03);
      check("R2 loaded address", int'(mem_addr), 3 * 1024);
      send(0, 8'hA5);
      check("R10 ready low while busy", int'(in_ready), 0);
      // R10 offer a byte while not ready: must not be taken
      in_valid = 1'b1; in_is_cmd = 1'b1; in_byte = 8'h12;
      @(negedge clk);
      in_valid = 1'b0;
      send(0, 8'h3C);
      drain();
      check("R3 address after two bytes", int'(mem_addr), m_addr);

      // R9 other command closes sequence
      send(1, 8'h12); send(0, 8'hFF);
      drain();
      check("R9 addr unchanged", int'(mem_addr), m_addr);

      // R5 resume
      send(1, 8'h68); send(0, 8'h81);
      drain();
      check("R5 resumed address", int'(mem_addr), m_addr);

      // R6 abandoned operand
      send(1, 8'h66); send(0, 8'h07); send(1, 8'h68);
      check("R6 addr kept", int'(mem_addr), m_addr);
      send(0, 8'hC3);
      drain();

      // R7 page beyond memory
      send(1, 8'h66); send(0, 8'h10); send(0, 8'h05);
      check("R7 modulo page", int'(mem_addr), 5 * 1024);
      send(0, 8'h0F);
      drain();

      // R8 wrap from last page
      send(1, 8'h66); send(0, 8'h0F); send(0, 8'hFF);
      check("R2 last page", int'(mem_addr), 4095 * 1024);
      for (int k = 0; k < 128; k++) send(0, 8'(8'h5A ^ k));
      drain();
      check("R8 address after wrap", int'(mem_addr), 0);
      send(0, 8'h96);
      drain();
      check("R3 queue empty", exp_q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule